// File: doc/BRIEF.md
# Three-State Strap Pin Configuration Reader

This block reads seven board-level strap pins once after every reset and turns them into the settings of a converter front end. Each pin can be tied low, tied high or left open. To tell these three cases apart, the block drives all pins through a shared weak driver. The drive alternates between high and low for a set number of phases. At the end of each phase the block samples every pad. A tied pin holds its level against the weak drive, while an open pin follows it.

After the scan, the block decodes the pin states and latches the result. The settings are the host configuration mode, the speed, the filter type, an oversampling ratio chosen by a two-pin code, the output lane arrangement and the frame header format. The block then raises `config_valid`. Pads found open are held low with a strong drive for the rest of operation. Changes on the pads after the scan have no effect until the next reset. If the mode pin selects serial-interface configuration, the remaining straps are not decoded.

The weak driver acts on all pins at once. The phase length (`SETTLE` cycles) and the number of high/low pairs (`TOGGLES`) are parameters.

Top module: `strap_cfg_reader`

## Requirements
- R1: While `rst_n` is low: `config_valid`=0, `strong_low`=0, `pin_error`=0 and all configuration fields are 0. `weak_en`=1 and `weak_val`=1.
- R2: Counting clock edges after reset release, the weak drive stays enabled for 2·TOGGLES phases of SETTLE cycles each. `weak_val` is 1 in even phases and 0 in odd phases. Each pad is sampled on the last cycle of each phase. After the scan, `weak_en`=0 and `weak_val`=0.
- R3: A pin is classified as follows. Read 1 in every sampled phase gives code 1. Read 0 in every phase gives code 0. Following the weak drive in every phase gives float, code 2. Any other pattern gives code 0 and sets `pin_error`. `pin_error` is never set in serial mode.
- R4: `config_valid` rises on the edge after the last sample, which is edge 2·TOGGLES·SETTLE+1 after release. It stays high until the next reset.
- R5: Pad changes after the scan do not change any output.
- R6: Pin 0 gives `cfg_host_mode`, where 0 = pin-configured with buffers on, 1 = serial-interface configured and 2 = pin-configured with buffers off. In mode 1, all other fields, `cfg_ratio` and `strong_low` stay 0.
- R7: Pins 1, 2, 5 and 6 give the following fields, each using the pin code directly:
  - `cfg_speed` (0 low, 1 max, 2 mid)
  - `cfg_filter` (0 wideband, 1 sinc4, 2 sinc4+sinc1)
  - `cfg_tdm` (0 all lanes, 1 one lane, 2 two lanes)
  - `cfg_header` (0 data only, 1 status+data, 2 status+data+CRC)
- R8: `cfg_ratio` is indexed by 3·code(pin3)+code(pin4).
  - Wideband: 32,64,128,256,512,1024,2048,4096,4096.
  - Sinc4: 12,16,24,32,64,128,256,1024,4096.
  - Sinc4+sinc1: 64,128,320,640,1280,3200,6400,12800,32000.
- R9: In the pin-configured modes, `strong_low[i]` is 1 exactly for pins classified as float, from the cycle `config_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 7 | Sampled pad levels (0 mode, 1 speed, 2 filter, 3 ratio high, 4 ratio low, 5 lanes, 6 header) |
| weak_en | output | 1 | Weak pad driver enable |
| weak_val | output | 1 | Weak pad driver level |
| strong_low | output | 7 | Strong low drive per pad |
| cfg_host_mode | output | 2 | Configuration mode |
| cfg_speed | output | 2 | Speed mode |
| cfg_filter | output | 2 | Filter type |
| cfg_ratio | output | 16 | Oversampling ratio |
| cfg_tdm | output | 2 | Lane arrangement |
| cfg_header | output | 2 | Frame header format |
| pin_error | output | 1 | Inconsistent strap reading |
| config_valid | output | 1 | Configuration latched |

## Verification
A wrong phase counter or settle counter shows at the weak drive on the very next cycle. It also shifts the rise of `config_valid` away from edge 2·TOGGLES·SETTLE+1. A bad accumulation of the per-pin readings stays hidden during the scan. It appears only on the cycle the fields latch, as a wrong code, a wrong ratio, a spurious `pin_error` or a wrong strong drive. Each pin is therefore given tied, open and inconsistent loads, and every output is compared on every cycle.

// File: rtl/strap_cfg_reader.sv
module strap_cfg_reader #(
  parameter int TOGGLES = 3,
  parameter int SETTLE  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  pad_in,
  output logic        weak_en,
  output logic        weak_val,
  output logic [6:0]  strong_low,
  output logic [1:0]  cfg_host_mode,
  output logic [1:0]  cfg_speed,
  output logic [1:0]  cfg_filter,
  output logic [15:0] cfg_ratio,
  output logic [1:0]  cfg_tdm,
  output logic [1:0]  cfg_header,
  output logic        pin_error,
  output logic        config_valid
);
  localparam int NPIN = 7;
  localparam int PHASES = 2 * TOGGLES;
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [CW-1:0] S_LAST = CW'(SETTLE - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PHASES - 1);

  typedef enum logic [1:0] {SCAN, DECIDE, DONE} state_t;
  state_t state;

  logic [CW-1:0] settle;
  logic [PW-1:0] phase;
  logic [NPIN-1:0] all_hi, all_lo, follows;
  logic [1:0] code [NPIN];
  logic [NPIN-1:0] bad;
  logic serial;

  assign weak_en  = (state == SCAN);
  assign weak_val = weak_en & ~phase[0];

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      code[i] = follows[i] ? 2'd2 : (all_hi[i] ? 2'd1 : 2'd0);
      bad[i]  = ~(follows[i] | all_hi[i] | all_lo[i]);
    end
  end
  assign serial = (code[0] == 2'd1);

  function automatic logic [15:0] ratio_of(input logic [1:0] flt, input logic [1:0] hi, input logic [1:0] lo);
    int idx;
    idx = 3 * int'(hi) + int'(lo);
    case (flt)
      2'd0: ratio_of = (idx == 8) ? 16'd4096 : 16'(32 << idx);
      2'd1: case (idx)
        0: ratio_of = 16'd12;   1: ratio_of = 16'd16;  2: ratio_of = 16'd24;
        3: ratio_of = 16'd32;   4: ratio_of = 16'd64;  5: ratio_of = 16'd128;
        6: ratio_of = 16'd256;  7: ratio_of = 16'd1024;
        default: ratio_of = 16'd4096;
      endcase
      default: case (idx)
        0: ratio_of = 16'd64;    1: ratio_of = 16'd128;   2: ratio_of = 16'd320;
        3: ratio_of = 16'd640;   4: ratio_of = 16'd1280;  5: ratio_of = 16'd3200;
        6: ratio_of = 16'd6400;  7: ratio_of = 16'd12800;
        default: ratio_of = 16'd32000;
      endcase
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SCAN;
      settle <= '0;
      phase <= '0;
      all_hi <= '1;
      all_lo <= '1;
      follows <= '1;
      strong_low <= '0;
      cfg_host_mode <= '0;
      cfg_speed <= '0;
      cfg_filter <= '0;
      cfg_ratio <= '0;
      cfg_tdm <= '0;
      cfg_header <= '0;
      pin_error <= 1'b0;
      config_valid <= 1'b0;
    end else begin
      case (state)
        SCAN: begin
          if (settle == S_LAST) begin
            settle <= '0;
            all_hi <= all_hi & pad_in;
            all_lo <= all_lo & ~pad_in;
            follows <= follows & ~(pad_in ^ {NPIN{weak_val}});
            if (phase == P_LAST) state <= DECIDE;
            else phase <= phase + 1'b1;
          end else begin
            settle <= settle + 1'b1;
          end
        end
        DECIDE: begin
          state <= DONE;
          phase <= '0;
          config_valid <= 1'b1;
          cfg_host_mode <= code[0];
          pin_error <= ~serial & (|bad);
          if (!serial) begin
            cfg_speed <= code[1];
            cfg_filter <= code[2];
            cfg_ratio <= ratio_of(code[2], code[3], code[4]);
            cfg_tdm <= code[5];
            cfg_header <= code[6];
            strong_low <= follows;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module strap_cfg_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        weak_en,
  input logic [6:0]  strong_low,
  input logic [1:0]  cfg_host_mode,
  input logic [1:0]  cfg_speed,
  input logic [1:0]  cfg_filter,
  input logic [15:0] cfg_ratio,
  input logic [1:0]  cfg_tdm,
  input logic [1:0]  cfg_header,
  input logic        pin_error,
  input logic        config_valid
);
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    config_valid |=> config_valid);
  a_r2_drive_off_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    config_valid |-> !weak_en);
  a_r9_strong_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|strong_low) |-> config_valid);
  a_r5_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    config_valid |=> ($stable(cfg_ratio) && $stable(strong_low) && $stable(cfg_host_mode)
                      && $stable(cfg_speed) && $stable(cfg_filter) && $stable(cfg_tdm)
                      && $stable(cfg_header) && $stable(pin_error)));
  a_r6_serial_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_host_mode == 2'd1) |-> (strong_low == '0 && cfg_ratio == '0 && !pin_error));
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_host_mode != 2'd3 && cfg_speed != 2'd3 && cfg_filter != 2'd3);
endmodule

bind strap_cfg_reader strap_cfg_reader_chk chk (.*);

// File: tb/tb_strap_cfg_reader.sv
`timescale 1ns/1ps
module tb_strap_cfg_reader;
  localparam int T = 3, S = 4, L = 2 * T * S;
  logic clk = 0, rst_n = 0;
  logic [6:0] pad_in;
  logic weak_en, weak_val, pin_error, config_valid;
  logic [6:0] strong_low;
  logic [1:0] cfg_host_mode, cfg_speed, cfg_filter, cfg_tdm, cfg_header;
  logic [15:0] cfg_ratio;

  strap_cfg_reader #(.TOGGLES(T), .SETTLE(S)) dut (.*);

  always #2.5 clk = ~clk;

  // pad load per pin: 0 tied low, 1 tied high, 2 open, 3 inconsistent
  int typ [7];
  int snap [7];
  int n = 0, vectors = 0, errors = 0;
  bit changed = 0, finished = 0;
  int wb [9] = '{32, 64, 128, 256, 512, 1024, 2048, 4096, 4096};
  int s4 [9] = '{12, 16, 24, 32, 64, 128, 256, 1024, 4096};
  int s41 [9] = '{64, 128, 320, 640, 1280, 3200, 6400, 12800, 32000};

  always_comb
    for (int i = 0; i < 7; i++)
      case (typ[i])
        0: pad_in[i] = 1'b0;
        1: pad_in[i] = 1'b1;
        2: pad_in[i] = weak_en ? weak_val : 1'b0;
        default: pad_in[i] = weak_en ? ~weak_val : 1'b0;
      endcase

  always @(posedge clk) begin
    if (!rst_n) begin n <= 0; snap <= typ; end
    else n <= n + 1;
  end

  task automatic chk(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at n=%0d: got %0d expected %0d", req, n, got, exp);
    end
  endtask

  function automatic int cv(int t); return (t == 3) ? 0 : t; endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 valid", config_valid, 0); chk("R1 strong", strong_low, 0);
      chk("R1 weak_en", weak_en, 1);    chk("R1 weak_val", weak_val, 1);
      chk("R1 ratio", cfg_ratio, 0);    chk("R1 error", pin_error, 0);
      chk("R1 fields", {cfg_host_mode, cfg_speed, cfg_filter, cfg_tdm, cfg_header}, 0);
    end else if (n < L) begin
      chk("R2 weak_en", weak_en, 1);
      chk("R2 weak_val", weak_val, ((n / S) % 2 == 0) ? 1 : 0);
      chk("R4 valid early", config_valid, 0);
    end else if (n == L) begin
      chk("R2 weak_en off", weak_en, 0);
      chk("R4 valid not yet", config_valid, 0);
    end else begin
      int m, ser, idx, flt, sl, bad;
      string tag;
      tag = changed ? "R5 " : "";
      m = cv(snap[0]); ser = (m == 1);
      flt = ser ? 0 : cv(snap[2]);
      idx = 3 * cv(snap[3]) + cv(snap[4]);
      sl = 0; bad = 0;
      for (int i = 0; i < 7; i++) begin
        if (snap[i] == 2) sl |= 1 << i;
        if (snap[i] == 3) bad = 1;
      end
      chk({tag, "R4 valid"}, config_valid, 1);
      chk({tag, "R2 weak_en"}, weak_en, 0);
      chk({tag, "R6 host_mode"}, cfg_host_mode, m);
      chk({tag, "R7 speed"}, cfg_speed, ser ? 0 : cv(snap[1]));
      chk({tag, "R7 filter"}, cfg_filter, flt);
      chk({tag, "R7 tdm"}, cfg_tdm, ser ? 0 : cv(snap[5]));
      chk({tag, "R7 header"}, cfg_header, ser ? 0 : cv(snap[6]));
      chk({tag, "R8 ratio"}, cfg_ratio, ser ? 0 : (flt == 0 ? wb[idx] : flt == 1 ? s4[idx] : s41[idx]));
      chk({tag, "R9 strong_low"}, strong_low, ser ? 0 : sl);
      chk({tag, "R3 pin_error"}, pin_error, ser ? 0 : bad);
    end
  end

  task automatic run(int t0, int t1, int t2, int t3, int t4, int t5, int t6);
    @(posedge clk); #1;
    rst_n = 0; changed = 0;
    typ = '{t0, t1, t2, t3, t4, t5, t6};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (L + 6) @(posedge clk);
    #1 typ = '{3, 2, 1, 3, 2, 1, 0}; changed = 1;
    repeat (8) @(posedge clk);
  endtask

  initial begin
    typ = '{0, 0, 0, 0, 0, 0, 0};
    run(0, 0, 0, 0, 0, 0, 0);
    run(2, 1, 2, 2, 1, 2, 1);
    run(1, 2, 2, 2, 2, 2, 2);
    run(0, 3, 1, 3, 0, 2, 3);
    run(3, 1, 1, 1, 1, 1, 1);
    for (int f = 0; f < 3; f++)
      for (int h = 0; h < 3; h++)
        for (int l = 0; l < 3; l++)
          run((f + h) % 2 == 0 ? 0 : 2, l, f, h, l, h, f);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule